// File: doc/BRIEF.md
# Thirty-Two-Bit Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a small processor datapath. It takes a 4-bit operation code, a first operand, a second operand that an external shifter has already prepared, the current condition flags, a request to update the flags, and the carry that the shifter produced. In the same cycle it forms a 32-bit result, a destination write-enable and the next value of the four condition flags (negative, zero, carry, overflow).

Sixteen operations are supported: add, add-with-carry, subtract, subtract-with-carry, the two reverse subtracts, AND, OR, XOR, AND-with-inverted-operand (bit clear), pass and pass-inverted, and four comparisons that only touch the flags. A one-stage output register with a valid strobe captures every accepted operation, so the surrounding pipeline or a bench can observe it one clock later.

Top module: `dp_alu`

## Requirements
- R1: Opcode 4 (add) gives a+b; opcode 5 (add with carry) gives a+b+C, where C is bit 1 of `flags_cur`. Flag bits are packed N=3, Z=2, C=1, V=0.
- R2: Opcode 2 (subtract) gives a-b; opcode 6 (subtract with carry) gives a-b-(1-C).
- R3: Opcode 3 (reverse subtract) gives b-a; opcode 7 (reverse subtract with carry) gives b-a-(1-C). With a=0x00000077 and b=0 the result is 0xFFFFFF89.
- R4: Opcode 0 gives a AND b, opcode 1 a XOR b, opcode 12 a OR b, opcode 14 a AND NOT b.
- R5: Opcode 13 passes b to the result; opcode 15 gives NOT b. Both write the destination.
- R6: Opcodes 8 (test AND), 9 (test XOR), 10 (compare, a-b) and 11 (compare negated, a+b) never assert the write-enable and always update the flags, whatever `set_flags` is.
- R7: For opcodes 0-7 and 12-15 with `set_flags` low, the next flags equal `flags_cur` exactly.
- R8: For arithmetic and compare operations, C is the adder carry-out (for subtraction this is NOT borrow) and V is set on signed overflow.
- R9: For logical, test and pass operations, C takes `shift_carry` and V keeps its current value.
- R10: When flags update, N equals result bit 31 and Z is set exactly when the result is zero.
- R11: One clock after `in_valid` is high, `out_valid` is high and `res_q`, `wr_q`, `flags_q` hold that operation's outputs; with `in_valid` low they hold their values and `out_valid` is low. Synchronous reset clears all registered outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 4 | Operation code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second (pre-shifted) operand |
| flags_cur | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | Request flag update |
| shift_carry | input | 1 | Carry-out of the operand shifter |
| result_o | output | 32 | Combinational result |
| wr_en_o | output | 1 | Combinational destination write-enable |
| flags_next_o | output | 4 | Combinational next flags {N,Z,C,V} |
| res_q | output | 32 | Registered result |
| wr_q | output | 1 | Registered write-enable |
| flags_q | output | 4 | Registered next flags |
| out_valid | output | 1 | Registered outputs hold a new operation |

## Verification
The bench targets signed overflow in both directions of add and subtract, a zero sum that carries out, and a subtraction that borrows, since a design that reported borrow instead of NOT borrow or checked overflow on the wrong operands would show a flipped C or V there. Carry-chained variants run with carry both set and clear, catching an inverted carry term that shifts the result by one. Compare and test operations run with `set_flags` low, exposing a design that writes the destination or gates their flags, and logical operations run with V set beforehand so that a design clearing V or ignoring the shifter carry shows a wrong flag word.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    localparam int unsigned DW = 32;

    typedef enum logic [3:0] {
        OP_AND   = 4'd0,
        OP_XOR   = 4'd1,
        OP_SUB   = 4'd2,
        OP_RSUB  = 4'd3,
        OP_ADD   = 4'd4,
        OP_ADDC  = 4'd5,
        OP_SUBC  = 4'd6,
        OP_RSUBC = 4'd7,
        OP_TAND  = 4'd8,
        OP_TXOR  = 4'd9,
        OP_CSUB  = 4'd10,
        OP_CADD  = 4'd11,
        OP_OR    = 4'd12,
        OP_PASS  = 4'd13,
        OP_CLR   = 4'd14,
        OP_PASSN = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic is_compare(input alu_op_e op);
        return (op == OP_TAND) || (op == OP_TXOR) || (op == OP_CSUB) || (op == OP_CADD);
    endfunction

    function automatic logic is_arith(input alu_op_e op);
        return (op inside {OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC, OP_CSUB, OP_CADD});
    endfunction

endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
    import dp_alu_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           ovf
);
    logic [W-1:0] x, y;
    logic         c0;
    logic [W:0]   full;

    always_comb begin
        x  = a;
        y  = b;
        c0 = 1'b0;
        unique case (op)
            OP_SUB, OP_CSUB: begin y = ~b; c0 = 1'b1; end
            OP_RSUB:         begin x = b; y = ~a; c0 = 1'b1; end
            OP_ADDC:         begin c0 = cin; end
            OP_SUBC:         begin y = ~b; c0 = cin; end
            OP_RSUBC:        begin x = b; y = ~a; c0 = cin; end
            default:         begin c0 = 1'b0; end
        endcase
    end

    assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c0};
    assign sum  = full[W-1:0];
    assign cout = full[W];
    assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/dp_alu_bitops.sv
module dp_alu_bitops
    import dp_alu_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND, OP_TAND: y = a & b;
            OP_XOR, OP_TXOR: y = a ^ b;
            OP_OR:           y = a | b;
            OP_PASS:         y = b;
            OP_CLR:          y = a & ~b;
            OP_PASSN:        y = ~b;
            default:         y = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu_flagnext.sv
module dp_alu_flagnext
    import dp_alu_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] res,
    input  logic         add_c,
    input  logic         add_v,
    input  logic         shc,
    input  logic         set_flags,
    input  flags_t       cur,
    output flags_t       nxt
);
    logic upd;
    assign upd = set_flags || is_compare(op);

    always_comb begin
        nxt = cur;
        if (upd) begin
            nxt.n = res[W-1];
            nxt.z = (res == '0);
            if (is_arith(op)) begin
                nxt.c = add_c;
                nxt.v = add_v;
            end else begin
                nxt.c = shc;
                nxt.v = cur.v;
            end
        end
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int unsigned W  = DW,
    localparam int unsigned FW = $bits(flags_t)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [3:0]    opcode,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [FW-1:0] flags_cur,
    input  logic          set_flags,
    input  logic          shift_carry,
    output logic [W-1:0]  result_o,
    output logic          wr_en_o,
    output logic [FW-1:0] flags_next_o,
    output logic [W-1:0]  res_q,
    output logic          wr_q,
    output logic [FW-1:0] flags_q,
    output logic          out_valid
);
    alu_op_e      op;
    flags_t       cur, nxt;
    logic [W-1:0] sum, lres;
    logic         cout, ovf;

    assign op  = alu_op_e'(opcode);
    assign cur = flags_t'(flags_cur);

    dp_alu_addsub #(.W(W)) u_add (
        .op(op), .a(op_a), .b(op_b), .cin(cur.c),
        .sum(sum), .cout(cout), .ovf(ovf)
    );

    dp_alu_bitops #(.W(W)) u_bit (
        .op(op), .a(op_a), .b(op_b), .y(lres)
    );

    assign result_o = is_arith(op) ? sum : lres;
    assign wr_en_o  = !is_compare(op);

    dp_alu_flagnext #(.W(W)) u_flg (
        .op(op), .res(result_o), .add_c(cout), .add_v(ovf),
        .shc(shift_carry), .set_flags(set_flags), .cur(cur), .nxt(nxt)
    );

    assign flags_next_o = nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            wr_q      <= 1'b0;
            flags_q   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q   <= result_o;
                wr_q    <= wr_en_o;
                flags_q <= flags_next_o;
            end
        end
    end
endmodule

// File: rtl/dp_alu_props.sv
module dp_alu_props #(
    parameter int unsigned W  = 32,
    parameter int unsigned FW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [3:0]    opcode,
    input logic [FW-1:0] flags_cur,
    input logic          set_flags,
    input logic [W-1:0]  result_o,
    input logic          wr_en_o,
    input logic [FW-1:0] flags_next_o,
    input logic [W-1:0]  res_q,
    input logic          wr_q,
    input logic [FW-1:0] flags_q,
    input logic          out_valid
);
    logic cmp_op, logic_op;
    assign cmp_op   = (opcode[3:2] == 2'b10);
    assign logic_op = (opcode inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15});

    assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        cmp_op |-> !wr_en_o);

    assert_hold_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (!cmp_op && !set_flags) |-> (flags_next_o == flags_cur));

    assert_keep_v_R9: assert property (@(posedge clk) disable iff (rst)
        logic_op |-> (flags_next_o[0] == flags_cur[0]));

    assert_sign_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (set_flags || cmp_op) |-> (flags_next_o[3] == result_o[W-1]));

    assert_capture_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && res_q == $past(result_o) && wr_q == $past(wr_en_o)
                      && flags_q == $past(flags_next_o)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(res_q) && $stable(flags_q)));
endmodule

bind dp_alu dp_alu_props #(.W(W), .FW(FW)) u_props (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .flags_cur(flags_cur), .set_flags(set_flags), .result_o(result_o),
    .wr_en_o(wr_en_o), .flags_next_o(flags_next_o), .res_q(res_q),
    .wr_q(wr_q), .flags_q(flags_q), .out_valid(out_valid)
);

// File: tb/test_dp_alu.sv
module test_dp_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [3:0]  flags_cur = '0;
    logic        set_flags = 1'b0, shift_carry = 1'b0;
    logic [31:0] result_o, res_q;
    logic        wr_en_o, wr_q, out_valid;
    logic [3:0]  flags_next_o, flags_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_alu i_dp_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .flags_cur(flags_cur), .set_flags(set_flags),
        .shift_carry(shift_carry), .result_o(result_o), .wr_en_o(wr_en_o),
        .flags_next_o(flags_next_o), .res_q(res_q), .wr_q(wr_q),
        .flags_q(flags_q), .out_valid(out_valid)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Drive one operation, wait for capture, check registered outputs.
    task automatic run_op(input string req, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [3:0] fc, input logic sf,
                          input logic shc, input bit chk_res, input logic [31:0] e_res,
                          input logic e_wr, input logic [3:0] e_fl);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; op_a = a; op_b = b;
        flags_cur = fc; set_flags = sf; shift_carry = shc;
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(req, "valid", {31'd0, out_valid}, 32'd1);
        if (chk_res) chk(req, "result", res_q, e_res);
        chk(req, "wr_en", {31'd0, wr_q}, {31'd0, e_wr});
        chk(req, "flags", {28'd0, flags_q}, {28'd0, e_fl});
    endtask

    task automatic t_reset;
        chk("R11", "reset valid", {31'd0, out_valid}, 32'd0);
        chk("R11", "reset result", res_q, 32'd0);
        chk("R11", "reset flags", {28'd0, flags_q}, 32'd0);
    endtask

    task automatic t_add;
        run_op("R1", 4'd4, 32'd5, 32'd10, 4'b0000, 1, 0, 1, 32'd15, 1, 4'b0000);
        run_op("R1", 4'd5, 32'd1, 32'd2, 4'b0010, 1, 0, 1, 32'd4, 1, 4'b0000);
        run_op("R1", 4'd5, 32'd1, 32'd2, 4'b0000, 1, 0, 1, 32'd3, 1, 4'b0000);
        run_op("R8", 4'd4, 32'h7FFFFFFF, 32'd1, 4'b0000, 1, 0, 1, 32'h80000000, 1, 4'b1001);
        run_op("R8", 4'd4, 32'hFFFFFFFF, 32'd1, 4'b0000, 1, 0, 1, 32'd0, 1, 4'b0110);
    endtask

    task automatic t_sub;
        run_op("R2", 4'd2, 32'd2, 32'd1, 4'b0000, 1, 0, 1, 32'd1, 1, 4'b0010);
        run_op("R8", 4'd2, 32'd1, 32'd2, 4'b0000, 1, 0, 1, 32'hFFFFFFFF, 1, 4'b1000);
        run_op("R2", 4'd6, 32'd5, 32'd3, 4'b0000, 1, 0, 1, 32'd1, 1, 4'b0010);
        run_op("R2", 4'd6, 32'd5, 32'd3, 4'b0010, 1, 0, 1, 32'd2, 1, 4'b0010);
        run_op("R8", 4'd2, 32'h80000000, 32'd1, 4'b0000, 1, 0, 1, 32'h7FFFFFFF, 1, 4'b0011);
    endtask

    task automatic t_rsub;
        run_op("R3", 4'd3, 32'h77, 32'd0, 4'b0000, 1, 0, 1, 32'hFFFFFF89, 1, 4'b1000);
        run_op("R3", 4'd7, 32'd1, 32'd5, 4'b0010, 1, 0, 1, 32'd4, 1, 4'b0010);
        run_op("R3", 4'd7, 32'd1, 32'd5, 4'b0000, 1, 0, 1, 32'd3, 1, 4'b0010);
    endtask

    task automatic t_logic;
        run_op("R4", 4'd12, 32'h02040608, 32'h10305070, 4'b0001, 1, 1, 1, 32'h12345678, 1, 4'b0011);
        run_op("R4", 4'd14, 32'hF, 32'h5, 4'b0000, 1, 0, 1, 32'hA, 1, 4'b0000);
        run_op("R10", 4'd0, 32'hF0, 32'h0F, 4'b0000, 1, 0, 1, 32'd0, 1, 4'b0100);
        run_op("R9", 4'd1, 32'hFF00, 32'h0FF0, 4'b0001, 1, 1, 1, 32'hF0F0, 1, 4'b0011);
    endtask

    task automatic t_move;
        run_op("R5", 4'd13, 32'd7, 32'h80000004, 4'b0000, 1, 1, 1, 32'h80000004, 1, 4'b1010);
        run_op("R7", 4'd15, 32'd7, 32'd0, 4'b0101, 0, 1, 1, 32'hFFFFFFFF, 1, 4'b0101);
    endtask

    task automatic t_compare;
        run_op("R6", 4'd10, 32'd4, 32'd4, 4'b0000, 0, 0, 0, 32'd0, 0, 4'b0110);
        run_op("R6", 4'd11, 32'd1, 32'hFFFFFFFF, 4'b1000, 0, 0, 0, 32'd0, 0, 4'b0110);
        run_op("R6", 4'd8, 32'd1, 32'd2, 4'b0001, 0, 0, 0, 32'd0, 0, 4'b0101);
        run_op("R6", 4'd9, 32'h80000000, 32'd0, 4'b0000, 0, 1, 0, 32'd0, 0, 4'b1010);
    endtask

    task automatic t_noflags;
        run_op("R7", 4'd4, 32'h7FFFFFFF, 32'd1, 4'b0110, 0, 0, 1, 32'h80000000, 1, 4'b0110);
        run_op("R7", 4'd12, 32'd0, 32'd0, 4'b1001, 0, 1, 1, 32'd0, 1, 4'b1001);
    endtask

    task automatic t_idle;
        logic [31:0] prev;
        prev = res_q;
        @(negedge clk);
        in_valid = 1'b0; opcode = 4'd4; op_a = 32'd100; op_b = 32'd200;
        @(posedge clk); #1;
        chk("R11", "idle valid", {31'd0, out_valid}, 32'd0);
        chk("R11", "idle hold", res_q, prev);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst = 1'b0;
        t_add();
        t_sub();
        t_rsub();
        t_logic();
        t_move();
        t_compare();
        t_noflags();
        t_idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule